// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is the target side of a two-wire serial EEPROM that holds 256 bytes. It watches the clock and data lines, recognises start and stop conditions, shifts bytes in and out, and answers each received byte with an acknowledge (data held low in the ninth clock) or leaves the line released as a not-acknowledge. It keeps one address pointer that is shared by writes, current-address reads, random reads and sequential reads.

Writes go into a page buffer of 2^PAGE_W bytes. A stop that ends a write carrying data starts a self-timed write cycle of WR_CYCLES system clocks, which copies the buffered bytes into the array. While that cycle runs the block does not answer its own address, so a host can poll for completion. A low-supply input blocks any write cycle from starting. Both bus lines pass through a synchroniser and a glitch filter, and the data line is only ever pulled low, through an output enable.

Top module: `i2c_eeprom_target`

## Requirements
- R1: In the cycle after reset and from then on until bus traffic, sda_oe_o and busy_o are both low.
- R2: A control byte is sent MSB first as 1010, then three select bits, then the direction bit (1 = read). The block acknowledges it only when the upper nibble is 1010 and the select bits equal CHIP_SEL. Otherwise it leaves SDA released in the ninth clock.
- R3: With CS_IGNORE set, any value of the three select bits is acknowledged, but a wrong upper nibble is still refused.
- R4: In a write, the block acknowledges the control byte, the word address and every data byte. A stop after at least one data byte raises busy_o for exactly WR_CYCLES clocks.
- R5: While busy_o is high, a control byte that matches is not acknowledged. Once busy_o falls, the same control byte is acknowledged.
- R6: A random read (word address write, repeated start, control byte with direction 1) returns the byte stored at that address.
- R7: When the host acknowledges a read byte, the block sends the byte at the next address. The address wraps from 255 to 0.
- R8: The pointer moves to one past each byte accessed. A current-address read returns the byte at the pointer. After a page write the pointer's low PAGE_W bits have advanced once per data byte and wrapped inside the page.
- R9: Data bytes of one write land at consecutive offsets inside the page addressed by the word address. The offset wraps within the page, and a later byte overwrites an earlier one at the same offset.
- R10: A repeated start after a write starts no write cycle, and any data bytes of that write are dropped. The pointer keeps the word address that was received.
- R11: A stop while low_supply_i is high starts no write cycle and leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | High pulls the data line low |
| low_supply_i | input | 1 | Supply-low indication; blocks write cycles |
| busy_o | output | 1 | Self-timed write cycle in progress |

## Verification
The bench builds the block with WR_CYCLES = 2000 and CHIP_SEL = 3'b101. This makes the write cycle longer than one start plus control byte, so a poll placed right after a stop lands inside the busy window and must be refused. A second instance built with CS_IGNORE = 1 listens to the same bus through its own data line, so the refusal of a wrong select code and its acceptance in the other variant are seen in the same slot. The filter length of 3 and a half bit period of 25 clocks leave enough margin for the block's acknowledge and data edges to settle before each sampling point.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,  // waiting for a start
    ST_CTRL,  // receiving control byte
    ST_CACK,  // acknowledging control byte
    ST_ADDR,  // receiving word address
    ST_AACK,  // acknowledging word address
    ST_WDAT,  // receiving write data
    ST_DACK,  // acknowledging write data
    ST_TX,    // sending a read byte
    ST_RACK   // host acknowledge slot after a read byte
  } ee_state_e;
endpackage

// File: rtl/i2c_ee_filter.sv
module i2c_ee_filter #(
  parameter int LINES  = 2,
  parameter int SYNC   = 2,
  parameter int STABLE = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] dout
);
  localparam int CW = $clog2(STABLE + 1);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [SYNC-1:0] sy;
    logic [CW-1:0]   run;
    logic            q;

    always_ff @(posedge clk) begin
      if (rst) begin
        sy  <= '1;
        run <= '0;
        q   <= 1'b1;
      end else begin
        sy <= {sy[SYNC-2:0], din[g]};
        if (sy[SYNC-1] == q) begin
          run <= '0;
        end else if (run == CW'(STABLE - 1)) begin
          q   <= sy[SYNC-1];
          run <= '0;
        end else begin
          run <= run + CW'(1);
        end
      end
    end

    assign dout[g] = q;
  end
endmodule

// File: rtl/i2c_ee_wcycle.sv
module i2c_ee_wcycle #(
  parameter int CYCLES = 5000,
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic [PAGE_W-1:0] idx,
  output logic              idx_vld
);
  localparam int PAGE = 1 << PAGE_W;
  localparam int CW   = $clog2(CYCLES + 1) > PAGE_W ? $clog2(CYCLES + 1) : PAGE_W + 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == CW'(CYCLES - 1)) busy <= 1'b0;
      cnt <= cnt + CW'(1);
    end
  end

  assign idx     = cnt[PAGE_W-1:0];
  assign idx_vld = busy && (cnt < CW'(PAGE));
endmodule

// File: rtl/i2c_ee_mem.sv
module i2c_ee_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] arr [1 << AW];

  always_ff @(posedge clk) begin
    if (we) arr[waddr] <= wdata;
    rdata <= arr[raddr];
  end
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import i2c_ee_pkg::*;
#(
  parameter int         PAGE_W      = 3,
  parameter int         WR_CYCLES   = 5000,
  parameter int         FILT_STABLE = 3,
  parameter bit         CS_IGNORE   = 1'b0,
  parameter logic [2:0] CHIP_SEL    = 3'b000
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o,
  input  logic low_supply_i,
  output logic busy_o
);
  localparam int AW   = 8;
  localparam int DW   = 8;
  localparam int PAGE = 1 << PAGE_W;
  localparam int PBW  = AW - PAGE_W;

  // line conditioning and edge detection
  logic [1:0] filt;
  logic       scl_f, sda_f, scl_q, sda_q;

  i2c_ee_filter #(.LINES(2), .SYNC(2), .STABLE(FILT_STABLE)) u_filt (
    .clk(clk), .rst(rst), .din({sda_i, scl_i}), .dout(filt)
  );
  assign scl_f = filt[0];
  assign sda_f = filt[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  logic scl_rise, scl_fall, start_det, stop_det;
  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;

  // protocol state
  ee_state_e         state;
  logic [2:0]        bitcnt;
  logic [DW-1:0]     sh;
  logic [DW-1:0]     tx;
  logic              byte_done;
  logic              rw_q;
  logic              m_ack;
  logic [AW-1:0]     ptr;
  logic [PBW-1:0]    page_base;
  logic [PAGE-1:0]   pvalid;
  logic              have_data;
  logic              wc_start;
  logic              busy;
  logic [PAGE_W-1:0] cidx;
  logic              cidx_vld;
  logic [DW-1:0]     rdata;
  logic [DW-1:0]     pbuf [PAGE];
  logic              ctrl_match;
  logic              pbuf_we;

  assign ctrl_match = (sh[7:4] == 4'b1010) && (CS_IGNORE || (sh[3:1] == CHIP_SEL));
  assign pbuf_we    = (state == ST_WDAT) && scl_fall && byte_done && !start_det && !stop_det;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      sh        <= '0;
      tx        <= '0;
      byte_done <= 1'b0;
      rw_q      <= 1'b0;
      m_ack     <= 1'b0;
      ptr       <= '0;
      page_base <= '0;
      pvalid    <= '0;
      have_data <= 1'b0;
      wc_start  <= 1'b0;
      sda_oe_o  <= 1'b0;
    end else begin
      wc_start <= 1'b0;
      if (start_det) begin
        state     <= ST_CTRL;
        bitcnt    <= '0;
        byte_done <= 1'b0;
        sda_oe_o  <= 1'b0;
        have_data <= 1'b0;
      end else if (stop_det) begin
        state     <= ST_IDLE;
        byte_done <= 1'b0;
        sda_oe_o  <= 1'b0;
        have_data <= 1'b0;
        if (have_data && !low_supply_i) wc_start <= 1'b1;
      end else begin
        case (state)
          ST_CTRL, ST_ADDR, ST_WDAT: begin
            if (scl_rise && !byte_done) begin
              sh     <= {sh[DW-2:0], sda_f};
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == 3'd7) byte_done <= 1'b1;
            end else if (scl_fall && byte_done) begin
              byte_done <= 1'b0;
              if (state == ST_CTRL) begin
                if (ctrl_match && !busy) begin
                  sda_oe_o <= 1'b1;
                  rw_q     <= sh[0];
                  state    <= ST_CACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_ADDR) begin
                sda_oe_o  <= 1'b1;
                ptr       <= sh;
                page_base <= sh[AW-1:PAGE_W];
                pvalid    <= '0;
                state     <= ST_AACK;
              end else begin
                sda_oe_o  <= 1'b1;
                pvalid[ptr[PAGE_W-1:0]] <= 1'b1;
                ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + PAGE_W'(1);
                have_data <= 1'b1;
                state     <= ST_DACK;
              end
            end
          end
          ST_CACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rw_q) begin
                tx       <= rdata;
                sda_oe_o <= ~rdata[DW-1];
                ptr      <= ptr + AW'(1);
                state    <= ST_TX;
              end else begin
                sda_oe_o <= 1'b0;
                state    <= ST_ADDR;
              end
            end
          end
          ST_AACK, ST_DACK: begin
            if (scl_fall) begin
              sda_oe_o <= 1'b0;
              bitcnt   <= '0;
              state    <= ST_WDAT;
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == 3'd7) begin
                sda_oe_o <= 1'b0;
                state    <= ST_RACK;
              end else begin
                sda_oe_o <= ~tx[DW-2];
                tx       <= {tx[DW-2:0], 1'b0};
                bitcnt   <= bitcnt + 3'd1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_f;
            end else if (scl_fall) begin
              if (m_ack) begin
                tx       <= rdata;
                sda_oe_o <= ~rdata[DW-1];
                ptr      <= ptr + AW'(1);
                bitcnt   <= '0;
                state    <= ST_TX;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // page buffer: plain registers, no reset
  always_ff @(posedge clk) begin
    if (pbuf_we) pbuf[ptr[PAGE_W-1:0]] <= sh;
  end

  i2c_ee_wcycle #(.CYCLES(WR_CYCLES), .PAGE_W(PAGE_W)) u_wcycle (
    .clk(clk), .rst(rst), .start(wc_start),
    .busy(busy), .idx(cidx), .idx_vld(cidx_vld)
  );

  i2c_ee_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk),
    .we(cidx_vld && pvalid[cidx]),
    .waddr({page_base, cidx}),
    .wdata(pbuf[cidx]),
    .raddr(ptr),
    .rdata(rdata)
  );

  assign busy_o = busy;
endmodule

// File: rtl/i2c_ee_chk.sv
module i2c_ee_chk
  import i2c_ee_pkg::*;
#(
  parameter int WR_CYCLES = 5000
) (
  input logic      clk,
  input logic      rst,
  input logic      busy,
  input logic      sda_oe,
  input logic      low_supply,
  input logic      stop_det,
  input logic      wc_start,
  input ee_state_e state
);
  localparam int CW = $clog2(WR_CYCLES + 2);
  logic [CW-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst || !busy) bcnt <= '0;
    else              bcnt <= bcnt + CW'(1);
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) $past(rst) |-> (!sda_oe && !busy));

  // R4
  wcycle_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (bcnt == CW'(WR_CYCLES)));

  // R4
  busy_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wc_start));

  // R4
  start_from_stop_chk: assert property (@(posedge clk) disable iff (rst)
    wc_start |-> $past(stop_det));

  // R5
  busy_nack_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CACK) |-> !busy);

  // R11
  low_supply_chk: assert property (@(posedge clk) disable iff (rst)
    wc_start |-> !$past(low_supply));
endmodule

bind i2c_eeprom_target i2c_ee_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .busy(busy_o), .sda_oe(sda_oe_o),
  .low_supply(low_supply_i), .stop_det(stop_det), .wc_start(wc_start),
  .state(state)
);

// File: tb/i2c_eeprom_target_bench.sv
module i2c_eeprom_target_bench;
  localparam int         H     = 25;
  localparam int         WRC   = 2000;
  localparam logic [2:0] CS    = 3'b101;
  localparam logic [7:0] CTL_W = {4'b1010, CS, 1'b0};
  localparam logic [7:0] CTL_R = {4'b1010, CS, 1'b1};
  localparam logic [15:0] VEC [6] = '{16'h005A, 16'h37C3, 16'h8011,
                                      16'hFF9E, 16'h5C42, 16'hA9E7};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1, low_sup = 1'b0;
  logic sda_oe, busy, sda_oe_any, busy_any;
  logic bus_sda, any_sda;
  int   nchk = 0, nfail = 0;
  logic any_ack;
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];

  always #5 clk = ~clk;

  assign bus_sda = m_sda & ~sda_oe;
  assign any_sda = m_sda & ~sda_oe_any;

  i2c_eeprom_target #(.WR_CYCLES(WRC), .FILT_STABLE(3), .CHIP_SEL(CS)) u_i2c_eeprom_target (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(bus_sda), .sda_oe_o(sda_oe),
    .low_supply_i(low_sup), .busy_o(busy)
  );

  i2c_eeprom_target #(.WR_CYCLES(WRC), .FILT_STABLE(3), .CHIP_SEL(CS), .CS_IGNORE(1'b1))
    u_i2c_eeprom_target_any (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(any_sda), .sda_oe_o(sda_oe_any),
    .low_supply_i(low_sup), .busy_o(busy_any)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hp();
    repeat (H) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; hp(); m_scl = 1'b1; hp(); m_sda = 1'b0; hp(); m_scl = 1'b0; hp();
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; hp(); m_scl = 1'b1; hp(); m_sda = 1'b1; hp();
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hp(); m_scl = 1'b1; hp(); m_scl = 1'b0;
    end
    m_sda = 1'b1; hp(); m_scl = 1'b1;
    repeat (H / 2) @(negedge clk);
    ack = ~bus_sda;
    any_ack = ~any_sda;
    repeat (H - H / 2) @(negedge clk);
    m_scl = 1'b0;
  endtask

  task automatic rd_byte(input logic ack_it, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hp(); m_scl = 1'b1;
      repeat (H / 2) @(negedge clk);
      b[i] = bus_sda;
      repeat (H - H / 2) @(negedge clk);
      m_scl = 1'b0;
    end
    m_sda = ~ack_it; hp(); m_scl = 1'b1; hp(); m_scl = 1'b0;
    m_sda = 1'b1;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    hp();
  endtask

  task automatic page_write(input logic [7:0] a, input int n);
    logic ack;
    i2c_start();
    wr_byte(CTL_W, ack); check(ack, "R4 control ack", ack, 1);
    wr_byte(a, ack);     check(ack, "R4 address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      wr_byte(wbuf[i], ack); check(ack, "R4 data ack", ack, 1);
    end
    i2c_stop();
  endtask

  task automatic seq_read_from(input logic [7:0] a, input int n);
    logic ack;
    i2c_start();
    wr_byte(CTL_W, ack); check(ack, "R6 control ack", ack, 1);
    wr_byte(a, ack);     check(ack, "R6 address ack", ack, 1);
    i2c_start();
    wr_byte(CTL_R, ack); check(ack, "R6 read control ack", ack, 1);
    for (int i = 0; i < n; i++) rd_byte(i < n - 1, rbuf[i]);
    i2c_stop();
  endtask

  task automatic cur_read(input int n);
    logic ack;
    i2c_start();
    wr_byte(CTL_R, ack); check(ack, "R8 control ack", ack, 1);
    for (int i = 0; i < n; i++) rd_byte(i < n - 1, rbuf[i]);
    i2c_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] exp_pg [8];
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    hp();

    // R2 / R3 wrong select bits
    i2c_start();
    wr_byte({4'b1010, 3'b011, 1'b0}, ack);
    check(!ack, "R2 wrong select refused", ack, 0);
    check(any_ack, "R3 wrong select accepted by variant", any_ack, 1);
    i2c_stop();
    // R2 / R3 wrong nibble
    i2c_start();
    wr_byte({4'b1011, CS, 1'b0}, ack);
    check(!ack, "R2 wrong nibble refused", ack, 0);
    check(!any_ack, "R3 wrong nibble refused by variant", any_ack, 0);
    i2c_stop();

    // table of single-byte writes with read-back
    for (int v = 0; v < 6; v++) begin
      wbuf[0] = VEC[v][7:0];
      page_write(VEC[v][15:8], 1);
      check(busy, "R4 busy after stop", busy, 1);
      wait_idle();
      seq_read_from(VEC[v][15:8], 1);
      check(rbuf[0] == VEC[v][7:0], "R6 random read", rbuf[0], VEC[v][7:0]);
    end

    // R9 page write of 10 bytes from offset 3 of page 0x40
    for (int i = 0; i < 10; i++) wbuf[i] = 8'hB0 + 8'(i);
    for (int i = 0; i < 10; i++) exp_pg[(3 + i) % 8] = 8'hB0 + 8'(i);
    page_write(8'h43, 10);
    // R5 poll while busy
    i2c_start();
    wr_byte(CTL_W, ack);
    check(!ack, "R5 refused while busy", ack, 0);
    i2c_stop();
    wait_idle();
    i2c_start();
    wr_byte(CTL_W, ack);
    check(ack, "R5 accepted after busy", ack, 1);
    i2c_stop();
    // R8 pointer at offset (3+10)%8 = 5
    cur_read(1);
    check(rbuf[0] == exp_pg[5], "R8 current read after page write", rbuf[0], exp_pg[5]);
    // R9 / R7 read back the whole page
    seq_read_from(8'h40, 8);
    for (int i = 0; i < 8; i++)
      check(rbuf[i] == exp_pg[i], "R9 page wrap content", rbuf[i], exp_pg[i]);

    // R7 wrap 255 -> 0
    seq_read_from(8'hFF, 2);
    check(rbuf[0] == VEC[3][7:0], "R7 byte at 255", rbuf[0], VEC[3][7:0]);
    check(rbuf[1] == VEC[0][7:0], "R7 wrap to 0", rbuf[1], VEC[0][7:0]);

    // R10 address only then repeated start
    i2c_start();
    wr_byte(CTL_W, ack);
    wr_byte(8'h80, ack);
    i2c_start();
    i2c_stop();
    check(!busy, "R10 no cycle after repeated start", busy, 0);
    cur_read(1);
    check(rbuf[0] == VEC[2][7:0], "R10 pointer kept", rbuf[0], VEC[2][7:0]);
    // R10 data dropped by repeated start
    i2c_start();
    wr_byte(CTL_W, ack);
    wr_byte(8'h5C, ack);
    wr_byte(8'hEE, ack);
    i2c_start();
    i2c_stop();
    check(!busy, "R10 data write dropped", busy, 0);
    seq_read_from(8'h5C, 1);
    check(rbuf[0] == VEC[4][7:0], "R10 array unchanged", rbuf[0], VEC[4][7:0]);

    // R11 low supply blocks the write cycle
    low_sup = 1'b1;
    wbuf[0] = 8'h11;
    page_write(8'h37, 1);
    check(!busy, "R11 no cycle under low supply", busy, 0);
    low_sup = 1'b0;
    hp();
    seq_read_from(8'h37, 1);
    check(rbuf[0] == VEC[1][7:0], "R11 array unchanged", rbuf[0], VEC[1][7:0]);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule